// File: doc/BRIEF.md
# Complementary PWM Channel with Dead-Time Insertion

This block is one pulse-width modulation channel. A 16-bit counter runs from zero up to a programmed period and then wraps. While the counter is below the programmed duty value, the channel's raw waveform is active. Two outputs are derived from the raw waveform:

- The high-side output follows the raw waveform.
- The low-side output follows its inverse.

Each side holds off its own rising edge by a programmable number of counter ticks. This keeps the two switches of a half-bridge from ever conducting together.

The counter does not advance on every clock. It advances only on cycles where the tick strobe picked by `clk_sel_i` is high. Period, duty and dead-time writes first go into staging registers. Software then raises an update request, and the staged set is copied into the working registers only on the next counter wrap. A setting change therefore never cuts a pulse short or leaves a runt. A start command loads the staged set directly and begins counting from zero. A stop command parks the channel with both outputs at their inactive level. An end-of-period pulse marks every wrap.

Top module: `cpwm_channel`

## Requirements
- R1: While the channel is stopped (after reset or after `disable_i`), the counter holds zero, `eop_o` is low, and both `hi_o` and `lo_o` sit at the inactive level, which is the inverse of `polarity_i`.
- R2: A pulse on `enable_i` while stopped starts the channel from count zero and loads the staged period, duty and dead-time into the working registers. `enable_i` while already running has no effect. `disable_i` wins over `enable_i` in the same cycle.
- R3: The counter advances only in cycles where `clk_en_i[clk_sel_i]` is high. It wraps to zero from the tick on which count+1 is greater than or equal to the period, so a period of N gives N ticks per cycle and a period of 0 acts as 1.
- R4: `eop_o` is high for exactly the clock cycle that follows each wrapping edge, and the counter reads zero in that cycle.
- R5: The raw waveform is active while the count is below the working duty. The high side is active once the raw waveform has stayed active for at least dead-time ticks after its rise.
- R6: The low side is active once the inverted raw waveform (channel running, count at or above duty) has stayed active for at least dead-time ticks after its rise.
- R7: When the dead-time is at least as long as an active or inactive interval, the matching side stays inactive for that whole interval. `hi_o` and `lo_o` are never both at the active level.
- R8: `polarity_i` = 1 makes the active level 1. `polarity_i` = 0 makes the active level 0 on both outputs.
- R9: Writes through `period_wr_i`, `duty_wr_i` and `dead_wr_i` only stage values. After an `upd_req_i` pulse, the staged set becomes the working set at the next wrap, and the working period changes at no other time while running.
- R10: Without an update request, wraps do not copy staged values. An update request without a following wrap changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clk_en_i | input | NUM_CLK (4) | Bank of divided-clock tick strobes |
| clk_sel_i | input | SEL_W (2) | Index of the strobe that advances the counter |
| enable_i | input | 1 | Start command pulse |
| disable_i | input | 1 | Stop command pulse |
| period_wr_i | input | 1 | Stage `period_i` |
| period_i | input | CNT_W (16) | Period in ticks |
| duty_wr_i | input | 1 | Stage `duty_i` |
| duty_i | input | CNT_W (16) | Active-interval length in ticks |
| dead_wr_i | input | 1 | Stage `dead_i` |
| dead_i | input | DT_W (16) | Rising-edge delay in ticks |
| upd_req_i | input | 1 | Arm copy of staged values at next wrap |
| polarity_i | input | 1 | Active output level |
| hi_o | output | 1 | High-side drive |
| lo_o | output | 1 | Low-side drive |
| eop_o | output | 1 | End-of-period pulse |

## Verification
The channel is driven with several input patterns:

- **Tick every cycle.** Gives exact period counts, so an off-by-one at the wrap shows up directly.
- **Sparse strobe on a non-zero select index.** Separates counting on the chosen strobe from counting on the clock or on the wrong bank bit.
- **Dead-time longer than the duty.** Shows whether a side stays fully suppressed rather than emitting a short pulse.
- **Randomized staged writes, update requests, start/stop commands and polarity flips.** A cycle-exact reference model compares every output on every cycle. This separates immediate application of a write from correct deferral to the wrap, and it exposes wrong command priorities.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;

  localparam int unsigned NUM_SIDES = 2;
  localparam int unsigned SIDE_HI   = 0;
  localparam int unsigned SIDE_LO   = 1;

  function automatic logic drive_level(input logic act, input logic pol);
    return pol ? act : ~act;
  endfunction

endpackage

// File: rtl/cpwm_tick_sel.sv
module cpwm_tick_sel #(
  parameter  int NUM_CLK = 4,
  localparam int SEL_W   = (NUM_CLK > 1) ? $clog2(NUM_CLK) : 1
) (
  input  logic [NUM_CLK-1:0] clk_en_i,
  input  logic [SEL_W-1:0]   sel_i,
  input  logic               run_i,
  output logic               tick_o
);

  logic hit;

  always_comb begin
    hit = 1'b0;
    for (int k = 0; k < NUM_CLK; k++) begin
      if (sel_i == SEL_W'(k)) hit = clk_en_i[k];
    end
  end

  assign tick_o = run_i & hit;

endmodule

// File: rtl/cpwm_timebase.sv
module cpwm_timebase #(
  parameter int CNT_W = 16,
  parameter int DT_W  = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             enable_i,
  input  logic             disable_i,
  input  logic             period_wr_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic             duty_wr_i,
  input  logic [CNT_W-1:0] duty_i,
  input  logic             dead_wr_i,
  input  logic [DT_W-1:0]  dead_i,
  input  logic             upd_req_i,
  output logic             en_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] per_o,
  output logic [CNT_W-1:0] duty_o,
  output logic [DT_W-1:0]  dead_o,
  output logic             eop_o
);

  logic             en_q, pend_q, eop_q;
  logic [CNT_W-1:0] cnt_q, per_q, duty_q;
  logic [CNT_W-1:0] per_b, duty_b;
  logic [DT_W-1:0]  dead_q, dead_b;
  logic [CNT_W:0]   cnt_inc;
  logic             wrap, start, commit;

  assign cnt_inc = {1'b0, cnt_q} + {{CNT_W{1'b0}}, 1'b1};
  assign wrap    = cnt_inc >= {1'b0, per_q};
  assign start   = enable_i & ~en_q & ~disable_i;
  assign commit  = tick_i & wrap & pend_q & ~disable_i;

  // staging registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      per_b  <= '0;
      duty_b <= '0;
      dead_b <= '0;
    end else begin
      if (period_wr_i) per_b  <= period_i;
      if (duty_wr_i)   duty_b <= duty_i;
      if (dead_wr_i)   dead_b <= dead_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= 1'b0;
    else         pend_q <= upd_req_i | (pend_q & ~commit & ~start);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      cnt_q  <= '0;
      eop_q  <= 1'b0;
      per_q  <= '0;
      duty_q <= '0;
      dead_q <= '0;
    end else if (disable_i) begin
      en_q  <= 1'b0;
      cnt_q <= '0;
      eop_q <= 1'b0;
    end else if (start) begin
      en_q   <= 1'b1;
      cnt_q  <= '0;
      eop_q  <= 1'b0;
      per_q  <= per_b;
      duty_q <= duty_b;
      dead_q <= dead_b;
    end else begin
      eop_q <= tick_i & wrap;
      if (tick_i) cnt_q <= wrap ? '0 : cnt_inc[CNT_W-1:0];
      if (commit) begin
        per_q  <= per_b;
        duty_q <= duty_b;
        dead_q <= dead_b;
      end
    end
  end

  assign en_o   = en_q;
  assign cnt_o  = cnt_q;
  assign per_o  = per_q;
  assign duty_o = duty_q;
  assign dead_o = dead_q;
  assign eop_o  = eop_q;

endmodule

// File: rtl/cpwm_dead_gen.sv
module cpwm_dead_gen #(
  parameter int DT_W = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            in_i,
  input  logic            tick_i,
  input  logic [DT_W-1:0] dead_i,
  output logic            act_o
);

  logic [DT_W-1:0] dt_q;

  // counts ticks since the side's input rose, saturating at the dead-time
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       dt_q <= '0;
    else if (!in_i)                    dt_q <= '0;
    else if (tick_i && dt_q < dead_i)  dt_q <= dt_q + 1'b1;
  end

  assign act_o = in_i & (dt_q >= dead_i);

endmodule

// File: rtl/cpwm_channel.sv
module cpwm_channel #(
  parameter  int CNT_W   = 16,
  parameter  int DT_W    = 16,
  parameter  int NUM_CLK = 4,
  localparam int SEL_W   = (NUM_CLK > 1) ? $clog2(NUM_CLK) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_CLK-1:0] clk_en_i,
  input  logic [SEL_W-1:0]   clk_sel_i,
  input  logic               enable_i,
  input  logic               disable_i,
  input  logic               period_wr_i,
  input  logic [CNT_W-1:0]   period_i,
  input  logic               duty_wr_i,
  input  logic [CNT_W-1:0]   duty_i,
  input  logic               dead_wr_i,
  input  logic [DT_W-1:0]    dead_i,
  input  logic               upd_req_i,
  input  logic               polarity_i,
  output logic               hi_o,
  output logic               lo_o,
  output logic               eop_o
);

  import cpwm_pkg::*;

  logic             en, tick, raw;
  logic [CNT_W-1:0] cnt, per_act, duty_act;
  logic [DT_W-1:0]  dead_act;
  logic [NUM_SIDES-1:0] side_in, side_act;

  cpwm_tick_sel #(.NUM_CLK(NUM_CLK)) i_tick_sel (
    .clk_en_i (clk_en_i),
    .sel_i    (clk_sel_i),
    .run_i    (en),
    .tick_o   (tick)
  );

  cpwm_timebase #(.CNT_W(CNT_W), .DT_W(DT_W)) i_timebase (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick),
    .enable_i    (enable_i),
    .disable_i   (disable_i),
    .period_wr_i (period_wr_i),
    .period_i    (period_i),
    .duty_wr_i   (duty_wr_i),
    .duty_i      (duty_i),
    .dead_wr_i   (dead_wr_i),
    .dead_i      (dead_i),
    .upd_req_i   (upd_req_i),
    .en_o        (en),
    .cnt_o       (cnt),
    .per_o       (per_act),
    .duty_o      (duty_act),
    .dead_o      (dead_act),
    .eop_o       (eop_o)
  );

  assign raw              = en & (cnt < duty_act);
  assign side_in[SIDE_HI] = raw;
  assign side_in[SIDE_LO] = en & ~raw;

  for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
    cpwm_dead_gen #(.DT_W(DT_W)) i_dead_gen (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .in_i   (side_in[s]),
      .tick_i (tick),
      .dead_i (dead_act),
      .act_o  (side_act[s])
    );
  end

  assign hi_o = drive_level(side_act[SIDE_HI], polarity_i);
  assign lo_o = drive_level(side_act[SIDE_LO], polarity_i);

endmodule

// File: rtl/cpwm_channel_chk.sv
module cpwm_channel_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             polarity_i,
  input logic             hi_o,
  input logic             lo_o,
  input logic             eop_o,
  input logic             en_q,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] per_q
);

  p_off_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q |-> (hi_o != polarity_i) && (lo_o != polarity_i) && cnt_q == '0);

  p_cnt_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_q |-> (cnt_q == '0 || cnt_q < per_q));

  p_eop_at_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eop_o |-> cnt_q == '0);

  p_no_overlap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !((hi_o == polarity_i) && (lo_o == polarity_i)));

  p_per_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q && $past(en_q) && !eop_o) |-> $stable(per_q));

endmodule

bind cpwm_channel cpwm_channel_chk #(.CNT_W(CNT_W)) i_cpwm_channel_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .polarity_i (polarity_i),
  .hi_o       (hi_o),
  .lo_o       (lo_o),
  .eop_o      (eop_o),
  .en_q       (en),
  .cnt_q      (cnt),
  .per_q      (per_act)
);

// File: tb/test_cpwm_channel.sv
module test_cpwm_channel;

  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 16;
  localparam int DT_W       = 16;
  localparam int NUM_CLK    = 4;

  logic               clk_i = 1'b0;
  logic               rst_ni = 1'b0;
  logic [NUM_CLK-1:0] clk_en_i = '0;
  logic [1:0]         clk_sel_i = '0;
  logic               enable_i = 0, disable_i = 0, upd_req_i = 0;
  logic               period_wr_i = 0, duty_wr_i = 0, dead_wr_i = 0;
  logic [CNT_W-1:0]   period_i = '0, duty_i = '0;
  logic [DT_W-1:0]    dead_i = '0;
  logic               polarity_i = 1'b1;
  logic               hi_o, lo_o, eop_o;

  int checks = 0, fails = 0;
  bit done = 0;
  string phase = "R1 reset";

  // reference model state
  bit m_en, m_pend, m_eop;
  int m_cnt, m_per, m_duty, m_dead, b_per, b_duty, b_dead, m_dth, m_dtl;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  cpwm_channel #(.CNT_W(CNT_W), .DT_W(DT_W), .NUM_CLK(NUM_CLK)) i_cpwm_channel (
    .clk_i, .rst_ni, .clk_en_i, .clk_sel_i, .enable_i, .disable_i,
    .period_wr_i, .period_i, .duty_wr_i, .duty_i, .dead_wr_i, .dead_i,
    .upd_req_i, .polarity_i, .hi_o, .lo_o, .eop_o
  );

  function automatic bit lvl(bit a, bit p);
    return p ? a : !a;
  endfunction

  function automatic bit m_raw();
    return m_en && (m_cnt < m_duty);
  endfunction

  function automatic bit exp_hi_act();
    return m_raw() && (m_dth >= m_dead);
  endfunction

  function automatic bit exp_lo_act();
    return (m_en && !m_raw()) && (m_dtl >= m_dead);
  endfunction

  task automatic model_next();
    bit tick, wrap, start, commit, in_h, in_l, pend_n;
    tick   = m_en && clk_en_i[clk_sel_i];
    wrap   = (m_cnt + 1) >= m_per;
    start  = enable_i && !m_en && !disable_i;
    commit = tick && wrap && m_pend && !disable_i;
    in_h   = m_raw();
    in_l   = m_en && !m_raw();
    m_dth  = !in_h ? 0 : ((tick && m_dth < m_dead) ? m_dth + 1 : m_dth);
    m_dtl  = !in_l ? 0 : ((tick && m_dtl < m_dead) ? m_dtl + 1 : m_dtl);
    pend_n = upd_req_i || (m_pend && !commit && !start);
    if (disable_i) begin
      m_en = 0; m_cnt = 0; m_eop = 0;
    end else if (start) begin
      m_en = 1; m_cnt = 0; m_eop = 0;
      m_per = b_per; m_duty = b_duty; m_dead = b_dead;
    end else begin
      m_eop = tick && wrap;
      if (tick) m_cnt = wrap ? 0 : m_cnt + 1;
      if (commit) begin
        m_per = b_per; m_duty = b_duty; m_dead = b_dead;
      end
    end
    m_pend = pend_n;
    if (period_wr_i) b_per  = int'(period_i);
    if (duty_wr_i)   b_duty = int'(duty_i);
    if (dead_wr_i)   b_dead = int'(dead_i);
  endtask

  task automatic check(string req, bit got, bit exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s (%s): got %0b expected %0b", req, phase, got, exp);
    end
  endtask

  task automatic compare();
    check("R5 hi_o", hi_o, lvl(exp_hi_act(), polarity_i));
    check("R6 lo_o", lo_o, lvl(exp_lo_act(), polarity_i));
    check("R4 eop_o", eop_o, m_eop);
  endtask

  task automatic step();
    model_next();
    @(negedge clk_i);
    compare();
    enable_i = 0; disable_i = 0; upd_req_i = 0;
    period_wr_i = 0; duty_wr_i = 0; dead_wr_i = 0;
  endtask

  task automatic stage(int p, int d, int t);
    period_i = CNT_W'(p); duty_i = CNT_W'(d); dead_i = DT_W'(t);
    period_wr_i = 1; duty_wr_i = 1; dead_wr_i = 1;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    int cnt_seen;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk_i);
    // R1: reset state, inactive level with polarity 1 is 0
    check("R1 reset hi_o", hi_o, 1'b0);
    check("R1 reset lo_o", lo_o, 1'b0);
    check("R1 reset eop_o", eop_o, 1'b0);
    rst_ni = 1;
    @(negedge clk_i);

    // R2/R3: start with period 5, duty 2, no dead-time, tick every cycle
    phase = "R2 start";
    clk_en_i = '1;
    stage(5, 2, 0); step();
    enable_i = 1; step();
    repeat (12) step();
    // R2: enable while running is ignored
    phase = "R2 re-enable ignored";
    enable_i = 1; step();
    repeat (7) step();

    // R10: staged period without update request must not apply
    phase = "R10 no request";
    stage(8, 3, 1); step();
    cnt_seen = 0;
    repeat (15) begin step(); if (eop_o) cnt_seen++; end
    check("R10 eop count over 15 cycles", cnt_seen == 3, 1'b1);

    // R9: request applies at next wrap
    phase = "R9 commit";
    upd_req_i = 1; step();
    repeat (20) step();

    // R7: dead-time longer than duty suppresses high side
    phase = "R7 long dead";
    stage(6, 2, 3); upd_req_i = 1; step();
    repeat (10) step();
    cnt_seen = 0;
    repeat (12) begin step(); if (hi_o) cnt_seen++; end
    check("R7 hi_o active cycles", cnt_seen == 0, 1'b1);

    // R8: inverted polarity
    phase = "R8 polarity low";
    polarity_i = 0;
    stage(7, 3, 1); upd_req_i = 1; step();
    repeat (20) step();
    polarity_i = 1;

    // R3: sparse strobe on select index 2
    phase = "R3 strobe select";
    clk_sel_i = 2'd2;
    for (int i = 0; i < 40; i++) begin
      clk_en_i = (i % 3 == 0) ? 4'b0100 : 4'b1011;
      step();
    end
    clk_en_i = '1;
    clk_sel_i = '0;

    // R1: stop parks outputs
    phase = "R1 stop";
    disable_i = 1; step();
    cnt_seen = 0;
    for (int i = 0; i < 8; i++) begin
      step();
      if (hi_o || lo_o || eop_o) cnt_seen++;
    end
    check("R1 idle after disable", cnt_seen == 0, 1'b1);
    // R2: disable wins over enable
    phase = "R2 priority";
    enable_i = 1; disable_i = 1; step();
    step();

    // randomized mix
    phase = "random R3 R5 R6 R9";
    for (int i = 0; i < 4000; i++) begin
      clk_en_i = NUM_CLK'($urandom);
      if ($urandom_range(0, 49) == 0) clk_sel_i = 2'($urandom);
      if ($urandom_range(0, 9) == 0)
        stage($urandom_range(0, 10), $urandom_range(0, 11), $urandom_range(0, 4));
      if ($urandom_range(0, 7) == 0) upd_req_i = 1;
      if ($urandom_range(0, 39) == 0) enable_i = 1;
      if ($urandom_range(0, 119) == 0) disable_i = 1;
      if ($urandom_range(0, 299) == 0) polarity_i = ~polarity_i;
      step();
    end

    done = 1;
    summary();
    $finish;
  end

endmodule